// File: doc/BRIEF.md
# Condition register field operation unit

This unit holds a 32-bit condition register split into eight 4-bit fields. Fields are numbered 0 to 7 starting from the most significant end, so field n occupies register bits [31-4n : 28-4n]. A 3-bit opcode picks one field-level operation per cycle.

Three operations write the register. The first merges chosen fields from a 64-bit source under an 8-bit field mask. The second copies a single field from the source, and only when the mask selects exactly one field. The third loads a chosen field from four carry/overflow status bits.

Three operations only read. The first extracts a single field in place. The second returns the whole register zero-extended to 64 bits. The third turns one field into a signed boolean value: minus one, one or zero.

The result and the "undefined" flag are combinational from the current register and the inputs. Writes take effect on the rising clock edge of a valid cycle. The unit sits beside an instruction decoder, which supplies the opcode and operands. The status register lives outside the unit.

Top module: `crf_unit`

## Requirements
- R1: After reset the register reads as zero through the whole-register read.
- R2: Opcode 4 (whole-register read) returns 32 zero bits in result_o[63:32] and the register in result_o[31:0]; it does not modify the register.
- R3: Opcode 1 (masked write) replaces field n with bits [31-4n:28-4n] of src_i wherever mask_i[7-n] is 1 and keeps the other fields; mask 8'h00 leaves the register unchanged.
- R4: Opcode 2 (single-field write) with exactly one mask bit set, mask_i[7-n], copies src_i[31-4n:28-4n] into field n only, with undef_o low.
- R5: Opcode 2 with zero or more than one mask bit set leaves the register unchanged and drives undef_o high.
- R6: Opcode 3 (single-field read) with exactly one mask bit set, mask_i[7-n], returns zero everywhere except result_o[31-4n:28-4n], which holds field n; undef_o is low.
- R7: Opcode 3 with zero or more than one mask bit set returns zero and drives undef_o high.
- R8: Opcode 5 (status load) writes flags_i into the field given by fidx_i, where flags_i[3]=OV, [2]=OV32, [1]=CA, [0]=CA32, placed from the field's most to least significant bit in that order.
- R9: Opcode 6 (boolean) examines the field given by fidx_i: when its most significant bit is 1 the result is all ones; otherwise when its next bit is 1 the result is 1; otherwise 0.
- R10: With valid_i low no operation changes the register.
- R11: undef_o is low for every opcode other than 2 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| valid_i | input | 1 | Operation valid this cycle |
| op_i | input | 3 | Opcode: 0 none, 1 masked write, 2 field write, 3 field read, 4 whole read, 5 status load, 6 boolean |
| mask_i | input | 8 | Field mask, bit 7-n selects field n |
| fidx_i | input | 3 | Field index for status load and boolean |
| src_i | input | 64 | Source operand, low word used |
| flags_i | input | 4 | Status bits OV, OV32, CA, CA32 from bit 3 down to bit 0 |
| result_o | output | 64 | Operation result |
| undef_o | output | 1 | Single-field operation with a mask not one-hot |

## Verification
The masked write is tried with a full mask, a mask of two separated fields and an empty mask. These cases tell a correct bit-replication order and merge apart from a reversed or shifted mask, and from a write that ignores the mask. The single-field moves are driven with a one-hot mask at each end of the register and with empty and two-bit masks. This separates the one-hot test from a mere non-zero test and shows that no field leaks on an undefined case. The status load uses asymmetric flag patterns so that a reversed packing order shows. The boolean operation is tried on fields whose top two bits are 11, 10, 01 and 00, which distinguishes the priority of the two bits.

// File: rtl/crf_pkg.sv
package crf_pkg;
  localparam int CRF_NF = 8;
  localparam int CRF_FW = 4;
  localparam int CRF_CW = CRF_NF * CRF_FW;
  localparam int CRF_IW = $clog2(CRF_NF);

  typedef enum logic [2:0] {
    CRF_NOP    = 3'd0,
    CRF_MASKWR = 3'd1,
    CRF_FLDWR  = 3'd2,
    CRF_FLDRD  = 3'd3,
    CRF_ALLRD  = 3'd4,
    CRF_STLOAD = 3'd5,
    CRF_BOOL   = 3'd6
  } crf_op_e;

  // field n sits at the most significant end for n = 0
  function automatic logic [CRF_FW-1:0] fld_get(input logic [CRF_CW-1:0] w,
                                                 input logic [CRF_IW-1:0] n);
    return w[(CRF_CW-1-CRF_FW*int'(n)) -: CRF_FW];
  endfunction

  function automatic logic [CRF_CW-1:0] fld_put(input logic [CRF_CW-1:0] w,
                                                 input logic [CRF_IW-1:0] n,
                                                 input logic [CRF_FW-1:0] v);
    logic [CRF_CW-1:0] r;
    r = w;
    for (int k = 0; k < CRF_NF; k++) begin
      if (k == int'(n)) r[(CRF_CW-1-CRF_FW*k) -: CRF_FW] = v;
    end
    return r;
  endfunction
endpackage

// File: rtl/crf_mask_expand.sv
module crf_mask_expand #(
  parameter int NF = crf_pkg::CRF_NF,
  parameter int FW = crf_pkg::CRF_FW,
  localparam int CW = NF * FW
) (
  input  logic [NF-1:0] mask_i,
  output logic [CW-1:0] mexp_o
);
  for (genvar g = 0; g < NF; g++) begin : g_fld
    assign mexp_o[(CW-1-FW*g) -: FW] = {FW{mask_i[NF-1-g]}};
  end
endmodule

// File: rtl/crf_onehot.sv
module crf_onehot #(
  parameter int NF = crf_pkg::CRF_NF,
  localparam int IW = $clog2(NF),
  localparam int CNTW = $clog2(NF + 1)
) (
  input  logic [NF-1:0] mask_i,
  output logic          oh_o,
  output logic [IW-1:0] idx_o
);
  logic [CNTW-1:0] cnt;

  always_comb begin
    cnt   = '0;
    idx_o = '0;
    for (int n = 0; n < NF; n++) begin
      if (mask_i[NF-1-n]) begin
        cnt   = cnt + 1'b1;
        idx_o = idx_o | IW'(n);
      end
    end
    oh_o = (cnt == CNTW'(1));
  end
endmodule

// File: rtl/crf_exec.sv
module crf_exec
  import crf_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [CRF_CW-1:0] crf_q_i,
  input  logic [CRF_CW-1:0] mexp_i,
  input  logic              oh_i,
  input  logic [CRF_IW-1:0] ohidx_i,
  input  logic [CRF_IW-1:0] fidx_i,
  input  logic [DW-1:0]     src_i,
  input  logic [CRF_FW-1:0] flags_i,
  output logic [DW-1:0]     res_o,
  output logic              undef_o,
  output logic              wr_en_o,
  output logic [CRF_CW-1:0] crf_d_o
);
  logic [CRF_CW-1:0] lo;
  logic [CRF_FW-1:0] nib;

  assign lo  = src_i[CRF_CW-1:0];
  assign nib = fld_get(crf_q_i, fidx_i);

  always_comb begin
    res_o   = '0;
    undef_o = 1'b0;
    wr_en_o = 1'b0;
    crf_d_o = crf_q_i;
    case (crf_op_e'(op_i))
      CRF_MASKWR: begin
        wr_en_o = valid_i;
        crf_d_o = (lo & mexp_i) | (crf_q_i & ~mexp_i);
      end
      CRF_FLDWR: begin
        if (oh_i) begin
          wr_en_o = valid_i;
          crf_d_o = fld_put(crf_q_i, ohidx_i, fld_get(lo, ohidx_i));
        end else begin
          undef_o = valid_i;
        end
      end
      CRF_FLDRD: begin
        if (oh_i) res_o[CRF_CW-1:0] = fld_put('0, ohidx_i, fld_get(crf_q_i, ohidx_i));
        else      undef_o = valid_i;
      end
      CRF_ALLRD: res_o[CRF_CW-1:0] = crf_q_i;
      CRF_STLOAD: begin
        wr_en_o = valid_i;
        crf_d_o = fld_put(crf_q_i, fidx_i, flags_i);
      end
      CRF_BOOL: begin
        if (nib[CRF_FW-1])      res_o = '1;
        else if (nib[CRF_FW-2]) res_o = DW'(1);
        else                    res_o = '0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/crf_unit.sv
module crf_unit
  import crf_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [CRF_NF-1:0] mask_i,
  input  logic [CRF_IW-1:0] fidx_i,
  input  logic [DW-1:0]     src_i,
  input  logic [CRF_FW-1:0] flags_i,
  output logic [DW-1:0]     result_o,
  output logic              undef_o
);
  logic              rst_meta_n, rst_q_n;
  logic [CRF_CW-1:0] crf_q, crf_d, mexp;
  logic              crf_en, oh;
  logic [CRF_IW-1:0] ohidx;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  crf_mask_expand #(.NF(CRF_NF), .FW(CRF_FW)) u_mexp (
    .mask_i (mask_i),
    .mexp_o (mexp)
  );

  crf_onehot #(.NF(CRF_NF)) u_oh (
    .mask_i (mask_i),
    .oh_o   (oh),
    .idx_o  (ohidx)
  );

  crf_exec #(.DW(DW)) u_exec (
    .valid_i (valid_i),
    .op_i    (op_i),
    .crf_q_i (crf_q),
    .mexp_i  (mexp),
    .oh_i    (oh),
    .ohidx_i (ohidx),
    .fidx_i  (fidx_i),
    .src_i   (src_i),
    .flags_i (flags_i),
    .res_o   (result_o),
    .undef_o (undef_o),
    .wr_en_o (crf_en),
    .crf_d_o (crf_d)
  );

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)    crf_q <= '0;
    else if (crf_en) crf_q <= crf_d;
  end
endmodule

// File: rtl/crf_checker.sv
module crf_checker
  import crf_pkg::*;
#(
  parameter int DW = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              valid_i,
  input logic [2:0]        op_i,
  input logic [CRF_NF-1:0] mask_i,
  input logic [DW-1:0]     src_i,
  input logic [DW-1:0]     result_o,
  input logic              undef_o,
  input logic [CRF_CW-1:0] crf_q
);
  logic bad_mask;
  assign bad_mask = ($countones(mask_i) != 1);

  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(crf_q));

  p_fldwr_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == CRF_FLDWR && bad_mask) |=> $stable(crf_q));

  p_undef_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    undef_o |-> (valid_i && bad_mask && (op_i == CRF_FLDWR || op_i == CRF_FLDRD)));

  p_fldrd_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == CRF_FLDRD && bad_mask) |-> (result_o == '0 && undef_o));

  p_full_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == CRF_MASKWR && mask_i == '1) |=> crf_q == $past(src_i[CRF_CW-1:0]));

  p_empty_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == CRF_MASKWR && mask_i == '0) |=> $stable(crf_q));

  p_allrd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == CRF_ALLRD) |-> result_o == {{(DW-CRF_CW){1'b0}}, crf_q});

  p_bool_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == CRF_BOOL) |-> (result_o == '1 || result_o == DW'(1) || result_o == '0));

  p_undef_other_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i != CRF_FLDWR && op_i != CRF_FLDRD) |-> !undef_o);
endmodule

bind crf_unit crf_checker #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .valid_i  (valid_i),
  .op_i     (op_i),
  .mask_i   (mask_i),
  .src_i    (src_i),
  .result_o (result_o),
  .undef_o  (undef_o),
  .crf_q    (crf_q)
);

// File: tb/tb_crf_unit.sv
`timescale 1ns/1ps
module tb_crf_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_i;
  logic [2:0]  op_i;
  logic [7:0]  mask_i;
  logic [2:0]  fidx_i;
  logic [63:0] src_i;
  logic [3:0]  flags_i;
  logic [63:0] result_o;
  logic        undef_o;

  int total = 0;
  int bad   = 0;
  logic [31:0] model;
  logic [63:0] got_res;
  logic        got_undef;

  always #5 clk = ~clk;

  crf_unit dut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .mask_i(mask_i),
    .fidx_i(fidx_i), .src_i(src_i), .flags_i(flags_i),
    .result_o(result_o), .undef_o(undef_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] nib(input logic [31:0] w, input int n);
    return w[31-4*n -: 4];
  endfunction

  function automatic logic [31:0] setnib(input logic [31:0] w, input int n, input logic [3:0] v);
    logic [31:0] r;
    r = w;
    r[31-4*n -: 4] = v;
    return r;
  endfunction

  // starts and ends at a falling edge; samples combinational outputs 1 ns later,
  // any write lands on the following rising edge
  task automatic issue(input logic v, input logic [2:0] op, input logic [7:0] m,
                       input logic [2:0] fi, input logic [63:0] s, input logic [3:0] fl);
    valid_i = v; op_i = op; mask_i = m; fidx_i = fi; src_i = s; flags_i = fl;
    #1;
    got_res   = result_o;
    got_undef = undef_o;
    @(negedge clk);
    valid_i = 1'b0; op_i = 3'd0;
  endtask

  task automatic read_all(input string req);
    issue(1'b1, 3'd4, 8'h00, 3'd0, 64'hFFFF_FFFF_0000_0000, 4'h0);
    check(req, got_res, {32'h0, model});
    check({req, " undef"}, {63'h0, got_undef}, 64'h0);
  endtask

  task automatic t_reset;
    read_all("R1");
  endtask

  task automatic mwrite(input logic [7:0] m, input logic [31:0] s);
    issue(1'b1, 3'd1, m, 3'd0, {32'hDEAD_BEEF, s}, 4'h0);
    check("R11 maskwr undef", {63'h0, got_undef}, 64'h0);
    for (int n = 0; n < 8; n++)
      if (m[7-n]) model = setnib(model, n, nib(s, n));
  endtask

  task automatic t_masked_write;
    mwrite(8'hFF, 32'h1234_5678);
    read_all("R3 full mask");
    mwrite(8'b1010_0000, 32'hFFFF_FFFF);
    check("R3 two fields", {32'h0, model}, 64'h0000_0000_F2F4_5678);
    read_all("R3 two fields");
    mwrite(8'h00, 32'h0000_0000);
    read_all("R3 empty mask");
    read_all("R2 hi zero");
  endtask

  task automatic t_field_write;
    issue(1'b1, 3'd2, 8'b0000_0001, 3'd0, 64'h0000_0000_AAAA_AAAB, 4'h0);
    check("R4 undef low", {63'h0, got_undef}, 64'h0);
    model = setnib(model, 7, 4'hB);
    read_all("R4 field7");
    issue(1'b1, 3'd2, 8'b1000_0000, 3'd0, 64'h0000_0000_9000_0000, 4'h0);
    model = setnib(model, 0, 4'h9);
    read_all("R4 field0");
    issue(1'b1, 3'd2, 8'b0000_0011, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 4'h0);
    check("R5 undef two bits", {63'h0, got_undef}, 64'h1);
    read_all("R5 unchanged two bits");
    issue(1'b1, 3'd2, 8'h00, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 4'h0);
    check("R5 undef empty", {63'h0, got_undef}, 64'h1);
    read_all("R5 unchanged empty");
  endtask

  task automatic t_field_read;
    issue(1'b1, 3'd3, 8'b0100_0000, 3'd0, 64'h0, 4'h0);
    check("R6 field1", got_res, {32'h0, setnib(32'h0, 1, nib(model, 1))});
    check("R6 undef low", {63'h0, got_undef}, 64'h0);
    issue(1'b1, 3'd3, 8'b0000_0001, 3'd0, 64'h0, 4'h0);
    check("R6 field7", got_res, {32'h0, setnib(32'h0, 7, nib(model, 7))});
    issue(1'b1, 3'd3, 8'b0001_0001, 3'd0, 64'h0, 4'h0);
    check("R7 result", got_res, 64'h0);
    check("R7 undef", {63'h0, got_undef}, 64'h1);
    issue(1'b1, 3'd3, 8'h00, 3'd0, 64'h0, 4'h0);
    check("R7 empty undef", {63'h0, got_undef}, 64'h1);
  endtask

  task automatic t_status_load;
    // OV=1 OV32=0 CA=1 CA32=0
    issue(1'b1, 3'd5, 8'h00, 3'd3, 64'h0, 4'b1010);
    model = setnib(model, 3, 4'b1010);
    read_all("R8 field3");
    // only CA32 set: lands in the field's least significant bit
    issue(1'b1, 3'd5, 8'h00, 3'd6, 64'h0, 4'b0001);
    model = setnib(model, 6, 4'b0001);
    read_all("R8 field6");
  endtask

  task automatic t_bool;
    logic [63:0] e;
    mwrite(8'hFF, 32'hC840_0000);
    read_all("R9 setup");
    for (int n = 0; n < 4; n++) begin
      issue(1'b1, 3'd6, 8'h00, 3'(n), 64'h0, 4'h0);
      if (nib(model, n)[3])      e = 64'hFFFF_FFFF_FFFF_FFFF;
      else if (nib(model, n)[2]) e = 64'h1;
      else                       e = 64'h0;
      check($sformatf("R9 field%0d", n), got_res, e);
      check("R11 bool undef", {63'h0, got_undef}, 64'h0);
    end
  endtask

  task automatic t_idle;
    issue(1'b0, 3'd1, 8'hFF, 3'd0, 64'h0000_0000_5555_5555, 4'h0);
    issue(1'b0, 3'd5, 8'h00, 3'd2, 64'h0, 4'hF);
    issue(1'b0, 3'd2, 8'h01, 3'd0, 64'h0000_0000_0000_000F, 4'h0);
    check("R10 undef", {63'h0, got_undef}, 64'h0);
    read_all("R10 unchanged");
  endtask

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; valid_i = 1'b0; op_i = 3'd0; mask_i = '0;
    fidx_i = '0; src_i = '0; flags_i = '0;
    model = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_masked_write();
    t_field_write();
    t_field_read();
    t_status_load();
    t_bool();
    t_idle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule